// File: doc/BRIEF.md
# Framed 24-Bit Serial Command Receiver

This block takes write-only commands for a 32-channel code memory over a three-wire serial link. It runs on the serial clock. While chip-select is low it shifts in 24-bit words, most significant bit first, one bit on each rising edge. Each complete word is split into a 12-bit code, a 5-bit channel address and two mode bits. The code and address then go out with a write strobe that lasts one cycle. A single chip-select period may carry any number of words back to back, and each one commits on its own. If chip-select rises in the middle of a word, that partial word is dropped.

The two stored mode bits are OR-combined with two external mode pins. The result is an immediate-update flag and an external-clock flag for the sequencer. While the sequencer runs its reset sweep, every serial input is ignored. The block also produces a frame-in-progress flag and a commit toggle. Each passes through a two-flop synchroniser into the sequencer clock domain.

The word engine has three states. ST_IDLE is entered whenever chip-select is high or reset is active. From ST_IDLE, the first rising edge with chip-select low moves to ST_SHIFT, or to ST_HOLD if a sweep is running. ST_SHIFT loops on itself, counting bits, and commits every 24th bit. It moves to ST_HOLD if the sweep input rises. ST_HOLD is left only by the asynchronous return to ST_IDLE when chip-select rises.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset the outputs are as follows:
    - `wr_en`, `wr_addr` and `wr_data` are 0.
    - The stored mode bits are 0, so `imm_mode` equals `imm_pin` and `ext_clk` equals `extclk_pin`.
    - `wr_toggle_sync` is 0.
- R2: A word is 24 bits, sampled on rising `sclk` edges with `cs_n` low, first bit received = bit 23. The fields are:
    - bits 23..12: the code;
    - bits 11..8: reserved;
    - bits 7..3: the address;
    - bit 2: the immediate bit;
    - bit 1: the external-clock bit;
    - bit 0: fill.

  `wr_addr` and `wr_data` show the fields from the rising edge that samples bit 0.
- R3: `wr_en` is high for exactly the one `sclk` cycle that follows the edge completing a word. The internal bit count never exceeds 23.
- R4: Words sent back to back within one low period of `cs_n` each commit separately, with their own fields.
- R5: If `cs_n` rises after a bit count that is not a multiple of 24, the partial word does not commit. The next frame starts a fresh word.
- R6: Nonzero reserved bits or a nonzero fill bit do not change the decoded fields.
- R7: The two mode flags are formed as follows:
    - `imm_mode` = stored immediate bit OR `imm_pin`.
    - `ext_clk` = stored external-clock bit OR `extclk_pin`.
    - Both stored bits are rewritten on every commit, so a word with bit 1 = 0 turns `ext_clk` off unless the pin is high.
- R8: While `sweep_busy` is high no word commits, and `wr_addr`/`wr_data` keep their values.
- R9: If `sweep_busy` is high on any sampling edge of a frame, nothing more in that frame commits, even after `sweep_busy` falls.
- R10: The frame and commit flags behave as follows:
    - `frame_active` is high exactly while `cs_n` is low.
    - `frame_active_sync` follows it through two `seq_clk` flops.
- R11: An internal toggle flips on every commit. `wr_toggle_sync` is that toggle after two `seq_clk` flops, so it settles to the parity of the number of commits.
- R12: `wr_en` rises only after an edge on which `cs_n` was low. Toggling `sdi` with `cs_n` high commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, also the block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip-select framing the words |
| sdi | input | 1 | Serial data, MSB first |
| sweep_busy | input | 1 | High while the reset sweep runs; input is ignored |
| imm_pin | input | 1 | External immediate-mode pin, OR-merged |
| extclk_pin | input | 1 | External clock-select pin, OR-merged |
| seq_clk | input | 1 | Sequencer clock for the synchronisers |
| seq_rst_n | input | 1 | Active-low reset of the synchronisers |
| wr_en | output | 1 | One-cycle write strobe per committed word |
| wr_addr | output | 5 | Channel address of the last committed word |
| wr_data | output | 12 | Code of the last committed word |
| imm_mode | output | 1 | Effective immediate-update flag |
| ext_clk | output | 1 | Effective external-clock flag |
| frame_active | output | 1 | Frame in progress (cs_n low) |
| frame_active_sync | output | 1 | frame_active in the sequencer domain |
| wr_toggle_sync | output | 1 | Commit toggle in the sequencer domain |

## Verification
The main stimulus is one frame of 32 back-to-back words that covers every address. Each word carries a code computed from its address, and its two mode bits together with the two mode pins run through all sixteen combinations. This separates field misplacement and merge-polarity errors from word-boundary errors.

Partial frames of 10 bits and of 31 bits (24 + 7) are used to tell discard errors from alignment errors. A word with all reserved and fill bits set shows whether those bits leak into the fields.

Frames sent with the sweep held high throughout, and with it raised only briefly mid-frame, tell a missing hold apart from one that is released too early. Pin toggling after a commit, and a word that clears the external-clock bit, show the merge is live and the stored bits are rewritten on every word.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
    localparam int CODE_W   = 12;
    localparam int RSV_W    = 4;
    localparam int ADDR_W   = 5;
    localparam int TAIL_W   = 3;
    localparam int WORD_W   = CODE_W + RSV_W + ADDR_W + TAIL_W;
    localparam int CNT_W    = $clog2(WORD_W);
    localparam int ADDR_LSB = TAIL_W;
    localparam int IMM_BIT  = 2;
    localparam int EXT_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/serial_cmd_shift.sv
module serial_cmd_shift
    import sercmd_pkg::*;
(
    input  logic              sclk,
    input  logic              frame_clr,
    input  logic              sdi,
    input  logic              sweep_busy,
    output logic              word_done,
    output logic [WORD_W-1:0] word_next
);
    rx_state_t         state, state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [WORD_W-2:0] sr, sr_nxt;

    assign word_next = {sr, sdi};

    // state register: cleared asynchronously while the frame is closed
    always_ff @(posedge sclk or posedge frame_clr) begin
        if (frame_clr) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sr    <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            sr    <= sr_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        sr_nxt    = sr;
        word_done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sweep_busy) begin
                    state_nxt = ST_HOLD;
                    cnt_nxt   = '0;
                end else begin
                    state_nxt = ST_SHIFT;
                    cnt_nxt   = CNT_W'(1);
                    sr_nxt    = word_next[WORD_W-2:0];
                end
            end
            ST_SHIFT: begin
                if (sweep_busy) begin
                    state_nxt = ST_HOLD;
                    cnt_nxt   = '0;
                end else if (cnt == CNT_W'(WORD_W - 1)) begin
                    word_done = 1'b1;
                    cnt_nxt   = '0;
                    sr_nxt    = word_next[WORD_W-2:0];
                end else begin
                    cnt_nxt   = cnt + CNT_W'(1);
                    sr_nxt    = word_next[WORD_W-2:0];
                end
            end
            ST_HOLD: begin
                state_nxt = ST_HOLD;
                cnt_nxt   = '0;
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    assert_cnt_range_R3: assert property (@(posedge sclk) disable iff (frame_clr)
        cnt < CNT_W'(WORD_W));

    assert_hold_sticky_R9: assert property (@(posedge sclk) disable iff (frame_clr)
        (state == ST_HOLD) |=> (state == ST_HOLD));
endmodule

// File: rtl/serial_cmd_decode.sv
module serial_cmd_decode
    import sercmd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              imm_lat,
    input  logic              ext_lat,
    input  logic              imm_pin,
    input  logic              extclk_pin,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] addr,
    output logic              imm_bit,
    output logic              ext_bit,
    output logic              imm_mode,
    output logic              ext_clk
);
    logic unused_bits;

    always_comb begin
        code     = word[WORD_W-1 -: CODE_W];
        addr     = word[ADDR_LSB +: ADDR_W];
        imm_bit  = word[IMM_BIT];
        ext_bit  = word[EXT_BIT];
        imm_mode = imm_lat | imm_pin;
        ext_clk  = ext_lat | extclk_pin;
    end

    // reserved and fill positions carry no meaning
    assign unused_bits = ^{word[ADDR_LSB + ADDR_W +: RSV_W], word[0]};
endmodule

// File: rtl/serial_cmd_sync.sv
module serial_cmd_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import sercmd_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              sweep_busy,
    input  logic              imm_pin,
    input  logic              extclk_pin,
    input  logic              seq_clk,
    input  logic              seq_rst_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CODE_W-1:0] wr_data,
    output logic              imm_mode,
    output logic              ext_clk,
    output logic              frame_active,
    output logic              frame_active_sync,
    output logic              wr_toggle_sync
);
    logic              frame_clr;
    logic              word_done;
    logic [WORD_W-1:0] word_next;
    logic [CODE_W-1:0] dec_code;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_imm, dec_ext;
    logic              imm_lat, ext_lat;
    logic              wr_tgl;
    logic [1:0]        sync_q;

    assign frame_clr    = cs_n | ~rst_n;
    assign frame_active = ~cs_n;

    serial_cmd_shift u_shift (
        .sclk       (sclk),
        .frame_clr  (frame_clr),
        .sdi        (sdi),
        .sweep_busy (sweep_busy),
        .word_done  (word_done),
        .word_next  (word_next)
    );

    serial_cmd_decode u_decode (
        .word       (word_next),
        .imm_lat    (imm_lat),
        .ext_lat    (ext_lat),
        .imm_pin    (imm_pin),
        .extclk_pin (extclk_pin),
        .code       (dec_code),
        .addr       (dec_addr),
        .imm_bit    (dec_imm),
        .ext_bit    (dec_ext),
        .imm_mode   (imm_mode),
        .ext_clk    (ext_clk)
    );

    // commit register: strobe, fields and stored mode bits
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            imm_lat <= 1'b0;
            ext_lat <= 1'b0;
            wr_tgl  <= 1'b0;
        end else begin
            wr_en <= word_done;
            if (word_done) begin
                wr_addr <= dec_addr;
                wr_data <= dec_code;
                imm_lat <= dec_imm;
                ext_lat <= dec_ext;
                wr_tgl  <= ~wr_tgl;
            end
        end
    end

    serial_cmd_sync #(.W(2)) u_sync (
        .clk   (seq_clk),
        .rst_n (seq_rst_n),
        .d     ({frame_active, wr_tgl}),
        .q     (sync_q)
    );

    assign frame_active_sync = sync_q[1];
    assign wr_toggle_sync    = sync_q[0];

    assert_wr_pulse_R3: assert property (@(posedge sclk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_sweep_blocks_R8: assert property (@(posedge sclk) disable iff (!rst_n)
        sweep_busy |=> !wr_en);

    assert_commit_in_frame_R12: assert property (@(posedge sclk) disable iff (!rst_n)
        wr_en |-> $past(!cs_n));
endmodule

// File: tb/serial_cmd_rx_bench.sv
module serial_cmd_rx_bench;
    logic        clk = 1'b0;
    logic        seq_clk = 1'b0;
    logic        rst_n, cs_n, sdi, sweep_busy, imm_pin, extclk_pin;
    logic        wr_en, imm_mode, ext_clk, frame_active, frame_active_sync, wr_toggle_sync;
    logic [4:0]  wr_addr;
    logic [11:0] wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    int n_wr    = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always #7 seq_clk = ~seq_clk;

    serial_cmd_rx u_serial_cmd_rx (
        .sclk              (clk),
        .rst_n             (rst_n),
        .cs_n              (cs_n),
        .sdi               (sdi),
        .sweep_busy        (sweep_busy),
        .imm_pin           (imm_pin),
        .extclk_pin        (extclk_pin),
        .seq_clk           (seq_clk),
        .seq_rst_n         (rst_n),
        .wr_en             (wr_en),
        .wr_addr           (wr_addr),
        .wr_data           (wr_data),
        .imm_mode          (imm_mode),
        .ext_clk           (ext_clk),
        .frame_active      (frame_active),
        .frame_active_sync (frame_active_sync),
        .wr_toggle_sync    (wr_toggle_sync)
    );

    always @(posedge clk) if (rst_n === 1'b1 && wr_en === 1'b1) n_wr++;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input logic [11:0] code, input logic [3:0] rsv,
                                       input logic [4:0] addr, input logic c1,
                                       input logic c0, input logic fill);
        return {code, rsv, addr, c1, c0, fill};
    endfunction

    // drives the top n bits of w, one per negedge; returns at the negedge after the last
    task automatic send_bits(input logic [23:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            cs_n = 1'b0;
            sdi  = w[23-i];
            if (n == 24 && i == 2)
                check(wr_en == 1'b0, "R3", "strobe gone inside word", int'(wr_en), 0);
        end
        @(negedge clk);
    endtask

    task automatic frame_end();
        cs_n = 1'b1;
        sdi  = 1'b0;
        @(negedge clk);
        check(wr_en == 1'b0, "R3", "strobe after frame end", int'(wr_en), 0);
    endtask

    task automatic expect_word(input string tag, input logic [4:0] a, input logic [11:0] c,
                               input logic im, input logic ex);
        check(wr_en == 1'b1, tag, "wr_en at commit", int'(wr_en), 1);
        check(wr_addr == a, tag, "wr_addr", int'(wr_addr), int'(a));
        check(wr_data == c, tag, "wr_data", int'(wr_data), int'(c));
        check(imm_mode == im, tag, "imm_mode", int'(imm_mode), int'(im));
        check(ext_clk == ex, tag, "ext_clk", int'(ext_clk), int'(ex));
    endtask

    task automatic wait_seq();
        repeat (3) @(posedge seq_clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int snap;
        logic [11:0] c;
        rst_n = 1'b0; cs_n = 1'b1; sdi = 1'b0;
        sweep_busy = 1'b0; imm_pin = 1'b0; extclk_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(wr_en == 1'b0, "R1", "wr_en", int'(wr_en), 0);
        check(wr_addr == 5'd0, "R1", "wr_addr", int'(wr_addr), 0);
        check(wr_data == 12'd0, "R1", "wr_data", int'(wr_data), 0);
        check(imm_mode == 1'b0 && ext_clk == 1'b0, "R1", "mode flags", int'({imm_mode, ext_clk}), 0);
        imm_pin = 1'b1; extclk_pin = 1'b1; #1;
        check(imm_mode && ext_clk, "R1", "flags follow pins", int'({imm_mode, ext_clk}), 3);
        imm_pin = 1'b0; extclk_pin = 1'b0;
        wait_seq();
        check(wr_toggle_sync == 1'b0, "R1", "toggle sync", int'(wr_toggle_sync), 0);
        check(frame_active == 1'b0, "R10", "frame_active idle", int'(frame_active), 0);
        @(negedge clk);

        // R12 data toggling with cs high
        for (int i = 0; i < 30; i++) begin
            sdi = i[0];
            @(negedge clk);
        end
        check(n_wr == 0, "R12", "commits with cs high", n_wr, 0);

        // R2 R4 R7: 32 back-to-back words, all addresses and all mode/pin combos
        for (int a = 0; a < 32; a++) begin
            c = 12'((a * 293 + 17) & 12'hFFF);
            imm_pin = a[2]; extclk_pin = a[3];
            send_bits(mk(c, 4'h0, 5'(a), a[0], a[1], 1'b0), 24);
            expect_word("R2", 5'(a), c, a[0] | a[2], a[1] | a[3]);
            if (a == 5) begin
                check(frame_active == 1'b1, "R10", "frame_active in frame", int'(frame_active), 1);
            end
        end
        imm_pin = 1'b0; extclk_pin = 1'b0;
        wait_seq();
        check(frame_active_sync == 1'b1, "R10", "frame_active_sync high", int'(frame_active_sync), 1);
        @(negedge clk);
        frame_end();
        check(n_wr == 32, "R4", "commits in one frame", n_wr, 32);
        wait_seq();
        check(frame_active_sync == 1'b0, "R10", "frame_active_sync low", int'(frame_active_sync), 0);
        check(wr_toggle_sync == 1'(n_wr & 1), "R11", "toggle parity", int'(wr_toggle_sync), n_wr & 1);
        @(negedge clk);

        // R5 partial word of 10 bits, then a full word
        snap = n_wr;
        send_bits(mk(12'hABC, 4'h0, 5'd9, 1'b1, 1'b1, 1'b0), 10);
        frame_end();
        check(n_wr == snap, "R5", "partial commits", n_wr, snap);
        send_bits(mk(12'h5A3, 4'h0, 5'd22, 1'b0, 1'b1, 1'b0), 24);
        expect_word("R5", 5'd22, 12'h5A3, 1'b0, 1'b1);
        // R5 24+7 bits: only one commit
        send_bits(mk(12'h111, 4'h0, 5'd3, 1'b0, 1'b0, 1'b0), 24);
        expect_word("R5", 5'd3, 12'h111, 1'b0, 1'b0);
        send_bits(mk(12'hFFF, 4'h0, 5'd31, 1'b1, 1'b1, 1'b0), 7);
        frame_end();
        check(n_wr == snap + 2, "R5", "commits for 31 bits", n_wr, snap + 2);
        check(wr_addr == 5'd3 && wr_data == 12'h111, "R5", "fields after tail", int'(wr_data), 12'h111);

        // R6 reserved and fill set
        send_bits(mk(12'h3C5, 4'hF, 5'd17, 1'b1, 1'b0, 1'b1), 24);
        expect_word("R6", 5'd17, 12'h3C5, 1'b1, 1'b0);

        // R7 external-clock bit must repeat; pins are live
        send_bits(mk(12'h020, 4'h0, 5'd4, 1'b0, 1'b1, 1'b0), 24);
        expect_word("R7", 5'd4, 12'h020, 1'b0, 1'b1);
        send_bits(mk(12'h021, 4'h0, 5'd5, 1'b0, 1'b0, 1'b0), 24);
        expect_word("R7", 5'd5, 12'h021, 1'b0, 1'b0);
        frame_end();
        extclk_pin = 1'b1; #1;
        check(ext_clk == 1'b1, "R7", "pin raises ext_clk", int'(ext_clk), 1);
        extclk_pin = 1'b0; imm_pin = 1'b1; #1;
        check(imm_mode == 1'b1 && ext_clk == 1'b0, "R7", "pin raises imm_mode", int'({imm_mode, ext_clk}), 2);
        imm_pin = 1'b0;
        @(negedge clk);

        // R8 sweep over a whole frame
        snap = n_wr;
        sweep_busy = 1'b1;
        send_bits(mk(12'hDEF, 4'h0, 5'd30, 1'b1, 1'b1, 1'b0), 24);
        send_bits(mk(12'h123, 4'h0, 5'd29, 1'b1, 1'b1, 1'b0), 24);
        frame_end();
        sweep_busy = 1'b0;
        check(n_wr == snap, "R8", "commits during sweep", n_wr, snap);
        check(wr_addr == 5'd5 && wr_data == 12'h021, "R8", "fields kept", int'(wr_data), 12'h021);
        check(imm_mode == 1'b0 && ext_clk == 1'b0, "R8", "mode kept", int'({imm_mode, ext_clk}), 0);

        // R9 brief sweep mid-frame blocks the rest of the frame
        send_bits(mk(12'h777, 4'h0, 5'd7, 1'b0, 1'b0, 1'b0), 5);
        sweep_busy = 1'b1;
        send_bits(24'h0, 3);
        sweep_busy = 1'b0;
        send_bits(mk(12'h888, 4'h0, 5'd8, 1'b0, 1'b0, 1'b0), 24);
        send_bits(mk(12'h999, 4'h0, 5'd9, 1'b0, 1'b0, 1'b0), 24);
        frame_end();
        check(n_wr == snap, "R9", "commits after released sweep", n_wr, snap);
        send_bits(mk(12'hAAA, 4'h0, 5'd10, 1'b1, 1'b0, 1'b0), 24);
        expect_word("R9", 5'd10, 12'hAAA, 1'b1, 1'b0);
        frame_end();
        wait_seq();
        check(wr_toggle_sync == 1'(n_wr & 1), "R11", "toggle parity end", int'(wr_toggle_sync), n_wr & 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule